// File: doc/BRIEF.md
# DRAM Request Burst Splitter

This block sits between an upstream request port and a DRAM command queue. Each incoming request carries a start address, a byte length and a read/write bit. The block turns it into one or two fixed 32-byte interface bursts. Each burst carries an address, the read/write bit, a per-byte write mask, the burst length in beats, and a flag that asks the queue to keep the DRAM page open for the burst that follows.

A mode input picks the data-path width. On the full 64-bit path a 32-byte burst is 4 beats long. On the half 32-bit path it is 8 beats long. The mode is captured when a request is accepted. Reads shorter than a burst are padded to a full burst. Short writes are carried by the write mask. Requests longer than 32 bytes are issued as two chained bursts.

Lengths the block cannot carry are consumed and answered with a one-cycle error pulse. No command is issued for them. This covers writes shorter than 8 bytes, because read-modify-write is handled elsewhere.

Top module: `dram_burst_splitter`

## Requirements
- R1: After reset, `cmdValid` and `reqErr` are low and `reqReady` is high.
- R2: `cmdBurstLen` is 4 for a request accepted with `halfWidth`=0 and 8 for one accepted with `halfWidth`=1. It applies to every burst of that request.
- R3: A read of 1 to 8, 16, 24 or 32 bytes produces exactly one burst with `cmdWrite`=0, `cmdAddr` equal to the request address, `cmdMask` all ones and `cmdKeepOpen`=0.
- R4: A 64-byte read produces two bursts with all-ones masks. The first goes to the request address with `cmdKeepOpen`=1. The second goes to the address plus 32 with `cmdKeepOpen`=0.
- R5: A write of 8, 16, 24 or 32 bytes produces one burst with `cmdKeepOpen`=0. Mask bit i refers to the byte at address+i, and 1 means written. Bits below the length are 1 and bits at or above it are 0.
- R6: A write of 40, 48, 56 or 64 bytes produces two bursts. The first has an all-ones mask and `cmdKeepOpen`=1. The second goes to the address plus 32, has `cmdKeepOpen`=0, and its mask has only the low (length−32) bits set.
- R7: Any other length or direction pair is illegal. This includes zero, reads of 40, 48 and 56, and writes of 1 to 7. An illegal request is accepted, raises `reqErr` for exactly the cycle after acceptance, and produces no burst.
- R8: `reqReady` is low while any burst of the current request is pending. A burst held with `cmdReady` low keeps all command fields unchanged until taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| halfWidth | input | 1 | 1 selects the 32-bit data path, 0 the 64-bit path |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | 32 | Start byte address, 32-byte aligned |
| reqLen | input | 7 | Request length in bytes |
| reqErr | output | 1 | One-cycle pulse for a rejected request |
| cmdValid | output | 1 | Burst command present |
| cmdReady | input | 1 | Command queue takes the burst |
| cmdWrite | output | 1 | Burst direction |
| cmdAddr | output | 32 | Burst start address |
| cmdMask | output | 32 | Per-byte write enable, bit i for byte address+i |
| cmdKeepOpen | output | 1 | Another burst of this request follows in the same page |
| cmdBurstLen | output | 4 | Beats in the burst (4 or 8) |

## Verification
The bench sweeps every length from 0 to 127 in both directions and both modes, so each legality boundary is hit exactly. Those boundaries are 7 versus 8 bytes for writes, 8 versus 16 for reads, and the read-only rejection of 40 to 56. A decoder that got the read/write split wrong would either emit a burst for a rejected length or pulse the error for a legal one. A mask shifted by one byte, or one applied to the first burst of a split write instead of the last, shows up as a wrong mask value on 40- and 8-byte writes. Random-looking stall patterns on the command side expose a design that advances the address or drops the keep-open flag before the burst is taken.

// File: rtl/burst_split_pkg.sv
package burst_split_pkg;

  typedef enum logic {SPLIT_IDLE, SPLIT_ISSUE} splitState_e;

  typedef struct packed {
    logic load;
    logic advance;
  } dpStrobe_t;

  function automatic logic lengthLegal(input logic isWrite, input int unsigned len);
    if (isWrite)
      return (len >= 8) && (len <= 64) && ((len % 8) == 0);
    else
      return ((len >= 1) && (len <= 8)) || (len == 16) || (len == 24) ||
             (len == 32) || (len == 64);
  endfunction

endpackage

// File: rtl/burst_split_ctrl.sv
module burst_split_ctrl
  import burst_split_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             cmdReady,
  input  logic             moreLeft,
  output logic             reqReady,
  output logic             reqErr,
  output logic             cmdValid,
  output dpStrobe_t        strobe
);

  splitState_e stateQ, stateD;
  logic accept, legal, errQ;

  assign reqReady = (stateQ == SPLIT_IDLE);
  assign cmdValid = (stateQ == SPLIT_ISSUE);
  assign accept   = reqValid && reqReady;
  assign legal    = lengthLegal(reqWrite, int'(reqLen));

  assign strobe.load    = accept && legal;
  assign strobe.advance = cmdValid && cmdReady && moreLeft;

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      SPLIT_IDLE:  if (strobe.load) stateD = SPLIT_ISSUE;
      SPLIT_ISSUE: if (cmdReady && !moreLeft) stateD = SPLIT_IDLE;
      default:     stateD = SPLIT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= SPLIT_IDLE;
      errQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      errQ   <= accept && !legal;
    end
  end

  assign reqErr = errQ;

  // R7: a rejection leaves no burst behind and the port free
  a_r7_err_idle: assert property (@(posedge clk) disable iff (!rstN)
    reqErr |-> (!cmdValid && reqReady));

  // R8: a held burst is never withdrawn
  a_r8_hold_valid: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> cmdValid);

  // R8: an accepted legal request blocks the upstream port next cycle
  a_r8_busy_after_load: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && legal) |=> !reqReady);

endmodule

// File: rtl/burst_split_datapath.sv
module burst_split_datapath
  import burst_split_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 7,
  parameter int UNIT_BYTES = 32,
  parameter int BUS_BITS   = 64,
  parameter int BEAT_W     = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strobe,
  input  logic                  halfWidth,
  input  logic                  reqWrite,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [LEN_W-1:0]      reqLen,
  output logic                  moreLeft,
  output logic                  cmdWrite,
  output logic [ADDR_W-1:0]     cmdAddr,
  output logic [UNIT_BYTES-1:0] cmdMask,
  output logic [BEAT_W-1:0]     cmdBurstLen
);

  localparam int BEATS_FULL = (UNIT_BYTES * 8) / BUS_BITS;
  localparam int BEATS_HALF = (UNIT_BYTES * 8) / (BUS_BITS / 2);

  logic [ADDR_W-1:0]     addrQ;
  logic                  writeQ, halfQ, moreQ;
  logic [UNIT_BYTES-1:0] tailMaskQ, tailMaskD;
  int unsigned           tailBytes;

  always_comb begin
    if (int'(reqLen) > UNIT_BYTES) tailBytes = int'(reqLen) - UNIT_BYTES;
    else                           tailBytes = int'(reqLen);
  end

  for (genvar i = 0; i < UNIT_BYTES; i++) begin : g_mask
    assign tailMaskD[i] = (i < tailBytes);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ     <= '0;
      writeQ    <= 1'b0;
      halfQ     <= 1'b0;
      moreQ     <= 1'b0;
      tailMaskQ <= '0;
    end else if (strobe.load) begin
      addrQ     <= reqAddr;
      writeQ    <= reqWrite;
      halfQ     <= halfWidth;
      moreQ     <= (int'(reqLen) > UNIT_BYTES);
      tailMaskQ <= tailMaskD;
    end else if (strobe.advance) begin
      addrQ     <= addrQ + ADDR_W'(UNIT_BYTES);
      moreQ     <= 1'b0;
    end
  end

  assign moreLeft    = moreQ;
  assign cmdWrite    = writeQ;
  assign cmdAddr     = addrQ;
  assign cmdMask     = (!writeQ || moreQ) ? '1 : tailMaskQ;
  assign cmdBurstLen = halfQ ? BEAT_W'(BEATS_HALF) : BEAT_W'(BEATS_FULL);

  // R6: a pending second burst always follows a full first burst
  a_r6_first_full: assert property (@(posedge clk) disable iff (!rstN)
    moreQ |-> (cmdMask == '1));

  // R4: chaining moves the address by one unit and ends the chain
  a_r4_next_unit: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> (addrQ == $past(addrQ) + ADDR_W'(UNIT_BYTES)) && !moreQ);

endmodule

// File: rtl/dram_burst_splitter.sv
module dram_burst_splitter
  import burst_split_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 7,
  parameter int UNIT_BYTES = 32,
  parameter int BUS_BITS   = 64,
  parameter int BEAT_W     = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  halfWidth,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic                  reqWrite,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [LEN_W-1:0]      reqLen,
  output logic                  reqErr,
  output logic                  cmdValid,
  input  logic                  cmdReady,
  output logic                  cmdWrite,
  output logic [ADDR_W-1:0]     cmdAddr,
  output logic [UNIT_BYTES-1:0] cmdMask,
  output logic                  cmdKeepOpen,
  output logic [BEAT_W-1:0]     cmdBurstLen
);

  dpStrobe_t strobe;
  logic      moreLeft;

  burst_split_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqLen   (reqLen),
    .cmdReady (cmdReady),
    .moreLeft (moreLeft),
    .reqReady (reqReady),
    .reqErr   (reqErr),
    .cmdValid (cmdValid),
    .strobe   (strobe)
  );

  burst_split_datapath #(
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .UNIT_BYTES (UNIT_BYTES),
    .BUS_BITS   (BUS_BITS),
    .BEAT_W     (BEAT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .halfWidth   (halfWidth),
    .reqWrite    (reqWrite),
    .reqAddr     (reqAddr),
    .reqLen      (reqLen),
    .moreLeft    (moreLeft),
    .cmdWrite    (cmdWrite),
    .cmdAddr     (cmdAddr),
    .cmdMask     (cmdMask),
    .cmdBurstLen (cmdBurstLen)
  );

  assign cmdKeepOpen = cmdValid && moreLeft;

  // R8: stalled burst keeps every field
  a_r8_stable_fields: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> ($stable(cmdAddr) && $stable(cmdMask) &&
      $stable(cmdWrite) && $stable(cmdKeepOpen) && $stable(cmdBurstLen)));

  // R4: a taken keep-open burst is followed by the closing burst one unit higher
  a_r4_chain: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && cmdKeepOpen) |=>
      (cmdValid && !cmdKeepOpen && cmdAddr == $past(cmdAddr) + ADDR_W'(UNIT_BYTES)));

  // R2: only the two legal beat counts appear
  a_r2_beats: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (cmdBurstLen == BEAT_W'(4) || cmdBurstLen == BEAT_W'(8)));

endmodule

// File: tb/dram_burst_splitter_test.sv
`timescale 1ns/1ps
module dram_burst_splitter_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        halfWidth = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [6:0]  reqLen = '0;
  logic        reqErr;
  logic        cmdValid;
  logic        cmdReady = 1'b0;
  logic        cmdWrite;
  logic [31:0] cmdAddr;
  logic [31:0] cmdMask;
  logic        cmdKeepOpen;
  logic [3:0]  cmdBurstLen;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dram_burst_splitter uut (
    .clk(clk), .rstN(rstN), .halfWidth(halfWidth),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqErr(reqErr),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdWrite(cmdWrite),
    .cmdAddr(cmdAddr), .cmdMask(cmdMask), .cmdKeepOpen(cmdKeepOpen),
    .cmdBurstLen(cmdBurstLen)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit legalRef(input bit w, input int len);
    if (w) return (len >= 8) && (len <= 64) && (len % 8 == 0);
    return (len >= 1 && len <= 8) || len == 16 || len == 24 || len == 32 || len == 64;
  endfunction

  task automatic runOne(input bit h, input bit w, input int len);
    bit          ok;
    int          n;
    int          tail;
    logic [31:0] addr;
    logic [31:0] expMask;
    logic [3:0]  expBeats;
    string       tagMain;
    ok       = legalRef(w, len);
    n        = (len > 32) ? 2 : 1;
    tail     = len - 32 * (n - 1);
    addr     = 32'((len * 7 + int'(w) * 3 + int'(h) * 11) * 32);
    expBeats = h ? 4'd8 : 4'd4;
    if (w) tagMain = (n == 2) ? "R6" : "R5";
    else   tagMain = (n == 2) ? "R4" : "R3";

    @(negedge clk);
    halfWidth = h; reqWrite = w; reqLen = 7'(len); reqAddr = addr; reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    halfWidth = ~h;
    if (!ok) begin
      chk(reqErr == 1'b1, "R7 err pulse", 64'(reqErr), 64'd1);
      chk(cmdValid == 1'b0, "R7 no burst", 64'(cmdValid), 64'd0);
      @(negedge clk);
      chk(reqErr == 1'b0, "R7 err single cycle", 64'(reqErr), 64'd0);
      chk(cmdValid == 1'b0 && reqReady == 1'b1, "R7 port free",
          64'({cmdValid, reqReady}), 64'b01);
      return;
    end
    chk(reqErr == 1'b0, "R7 no err on legal", 64'(reqErr), 64'd0);
    for (int b = 0; b < n; b++) begin
      int stall = (len + b + int'(h)) % 3;
      expMask = (!w || b < n - 1) ? 32'hFFFF_FFFF :
                ((tail >= 32) ? 32'hFFFF_FFFF : ((32'h1 << tail) - 32'h1));
      for (int s = 0; s <= stall; s++) begin
        chk(cmdValid == 1'b1, {tagMain, " valid"}, 64'(cmdValid), 64'd1);
        chk(cmdAddr == addr + 32'(32 * b), {tagMain, " addr"}, 64'(cmdAddr),
            64'(addr + 32'(32 * b)));
        chk(cmdWrite == w, {tagMain, " dir"}, 64'(cmdWrite), 64'(w));
        chk(cmdMask == expMask, {tagMain, " mask"}, 64'(cmdMask), 64'(expMask));
        chk(cmdKeepOpen == (b < n - 1), {tagMain, " keep open"}, 64'(cmdKeepOpen),
            64'(b < n - 1));
        chk(cmdBurstLen == expBeats, "R2 beats", 64'(cmdBurstLen), 64'(expBeats));
        chk(reqReady == 1'b0, "R8 busy", 64'(reqReady), 64'd0);
        if (s < stall) @(negedge clk);
      end
      cmdReady = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cmdReady = 1'b0;
    end
    chk(cmdValid == 1'b0 && reqReady == 1'b1, {tagMain, " done count"},
        64'({cmdValid, reqReady}), 64'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cmdValid == 1'b0 && reqErr == 1'b0 && reqReady == 1'b1, "R1 reset",
        64'({cmdValid, reqErr, reqReady}), 64'b001);
    rstN = 1'b1;
    @(negedge clk);
    chk(cmdValid == 1'b0 && reqReady == 1'b1, "R1 after release",
        64'({cmdValid, reqReady}), 64'b01);
    for (int h = 0; h < 2; h++)
      for (int w = 0; w < 2; w++)
        for (int len = 0; len < 128; len++)
          runOne(h[0], w[0], len);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      testCnt++;
      failCnt++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule